// File: doc/BRIEF.md
# Transmit Collision Retry Controller

This block runs the transmission attempts for one frame at a time on a half-duplex shared medium. A frame request arrives on a valid/ready handshake. The controller then commands the first attempt and watches the medium's outcome. An attempt either ends cleanly, or it is hit by a collision that is tagged as normal or late. After a normal collision the controller waits a random truncated binary exponential backoff, counted in slot times, and then commands the next attempt. When the frame is finished it raises a one-cycle done strobe and presents a status word. The word holds a retry error flag, a late collision flag and the number of attempts made.

Two policy bits are captured when a frame is accepted. The single-attempt bit gives up on the frame at its first collision and reports a retry error. The late-retransmit bit makes a late collision count as an ordinary retryable collision. With that bit clear, a late collision abandons the frame. A late collision always sets the late flag in the status, whichever policy is in force. The request handshake provides the back-pressure. `frame_ready_o` is high only while no frame is in progress, and a request counts only in a cycle where both `frame_valid_i` and `frame_ready_o` are high. The requester may hold `frame_valid_i` high for as long as it likes. The done strobe and the status are plain outputs with no handshake.

Top module: `txretry_ctrl`

## Requirements
- R1: After reset, `frame_ready_o` is 1. `attempt_start_o`, `done_o`, `stat_retry_err_o`, `stat_late_o` and `stat_attempts_o` are 0, and both captured policy bits are 0.
- R2: A frame is accepted on a clock edge where `frame_valid_i` and `frame_ready_o` are both 1. `attempt_start_o` is 1 in the following cycle. `frame_ready_o` stays 0 from then until the cycle in which `done_o` is 1, and `frame_valid_i` has no effect while `frame_ready_o` is 0.
- R3: While an attempt is in progress, `tx_end_i` with no `coll_i` finishes the frame. `done_o` is 1 in the next cycle, with `stat_retry_err_o` = 0 and `stat_attempts_o` equal to the number of attempts made.
- R4: A retryable collision during attempt n starts a backoff. The next `attempt_start_o` pulse comes w cycles after the collision edge, where w = r*SLOT_CYCLES+1 and 0 <= r < 2^min(n,BO_LIMIT). r is drawn from a free-running 16-bit LFSR.
- R5: A retryable collision on attempt MAX_ATTEMPTS (16 by default) ends the frame with `stat_retry_err_o` = 1 and `stat_attempts_o` = MAX_ATTEMPTS.
- R6: With the single-attempt bit set, the first collision ends the frame with `stat_retry_err_o` = 1 and `stat_attempts_o` = 1, and no further attempt is started.
- R7: With the late-retransmit bit clear, a collision with `coll_late_i` = 1 abandons the frame. The status is `stat_retry_err_o` = 0 and `stat_late_o` = 1.
- R8: With the late-retransmit bit set, a late collision is handled like a normal collision. `stat_late_o` is 1 in the final status of that frame, even when a later attempt succeeds.
- R9: `done_o` is a single-cycle pulse given exactly once per accepted frame. The status outputs change only in a cycle where `done_o` is 1.
- R10: If `coll_i` and `tx_end_i` are both 1 on the same edge during an attempt, the collision takes priority.
- R11: The policy bits are sampled only when a frame is accepted. Changing `cfg_single_try_i` or `cfg_late_retx_i` during a frame has no effect on that frame.
- R12: `coll_i`, `coll_late_i` and `tx_end_i` are ignored while no attempt is in progress, that is when idle or during backoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_single_try_i | input | 1 | Single-attempt policy, captured at accept |
| cfg_late_retx_i | input | 1 | Retransmit-after-late-collision policy, captured at accept |
| frame_valid_i | input | 1 | Frame request valid |
| frame_ready_o | output | 1 | Controller can accept a frame |
| coll_i | input | 1 | Collision seen on the current attempt |
| coll_late_i | input | 1 | Qualifies `coll_i` as a late collision |
| tx_end_i | input | 1 | Current attempt completed cleanly |
| attempt_start_o | output | 1 | One-cycle command to start an attempt |
| done_o | output | 1 | One-cycle frame-finished strobe |
| stat_retry_err_o | output | 1 | Frame ended by retry exhaustion or by a single-attempt collision |
| stat_late_o | output | 1 | A late collision occurred during the frame |
| stat_attempts_o | output | 5 | Attempts made for the last finished frame |

## Verification
A corrupted attempt counter shows up at the ports in two ways. The retry error arrives one collision early or late, and the attempt field reads wrong at the very next done strobe. A counter that is never reloaded shows at once, because the next frame's count starts from a stale value. A wrong backoff mask or a timer that is never loaded shows within one backoff window: the restart pulse arrives before or after the bound for that attempt number. A lost late flag or a stuck state shows as a wrong status bit or a missing done strobe on the same frame, and the reference model flags it in that cycle.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_BACKOFF = 2'd2
  } txr_state_e;

  typedef struct packed {
    logic       retry_err;
    logic       late;
  } txr_flags_t;
endpackage

// File: rtl/txr_lfsr.sv
module txr_lfsr #(
  parameter int          OUT_W = 10,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rand_o
);
  logic [15:0] sh_q;
  logic        fb;

  // taps 16,14,13,11 give a maximal-length sequence
  assign fb = sh_q[15] ^ sh_q[13] ^ sh_q[12] ^ sh_q[10];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sh_q <= SEED;
    else         sh_q <= {sh_q[14:0], fb};
  end

  assign rand_o = sh_q[OUT_W-1:0];

  assert_lfsr_alive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_q != 16'h0000);
endmodule

// File: rtl/txr_backoff.sv
module txr_backoff #(
  parameter int CNT_W       = 5,
  parameter int SLOT_CYCLES = 4,
  parameter int BO_LIMIT    = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    attempt_i,
  input  logic [BO_LIMIT-1:0] rand_i,
  output logic                expired_o
);
  localparam int SLOT_W = $clog2(SLOT_CYCLES + 1);
  localparam int TMR_W  = BO_LIMIT + SLOT_W;
  localparam logic [TMR_W-1:0] SLOT_T = TMR_W'(SLOT_CYCLES);

  logic [CNT_W-1:0]    k;
  logic [BO_LIMIT-1:0] mask;
  logic [BO_LIMIT-1:0] draw;
  logic [TMR_W-1:0]    lim;
  logic [TMR_W-1:0]    cnt_q;

  always_comb begin
    k    = (32'(attempt_i) > BO_LIMIT) ? CNT_W'(BO_LIMIT) : attempt_i;
    mask = ~({BO_LIMIT{1'b1}} << k);
    draw = rand_i & mask;
    lim  = {{SLOT_W{1'b0}}, mask} * SLOT_T;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= {{SLOT_W{1'b0}}, draw} * SLOT_T;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R4: the loaded wait never exceeds the window for this attempt number
  assert_bo_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q <= $past(lim)));
endmodule

// File: rtl/txretry_ctrl.sv
module txretry_ctrl
  import txr_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int SLOT_CYCLES  = 4,
  parameter int BO_LIMIT     = 10,
  localparam int CNT_W       = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_single_try_i,
  input  logic             cfg_late_retx_i,
  input  logic             frame_valid_i,
  output logic             frame_ready_o,
  input  logic             coll_i,
  input  logic             coll_late_i,
  input  logic             tx_end_i,
  output logic             attempt_start_o,
  output logic             done_o,
  output logic             stat_retry_err_o,
  output logic             stat_late_o,
  output logic [CNT_W-1:0] stat_attempts_o
);
  localparam logic [CNT_W-1:0] MAX_T = CNT_W'(MAX_ATTEMPTS);

  txr_state_e          state_q;
  logic [CNT_W-1:0]    att_q;
  logic                late_q;
  logic                single_q;
  logic                lretx_q;
  logic                start_q;
  logic                done_q;
  txr_flags_t          flags_q;
  logic [CNT_W-1:0]    stat_att_q;

  logic                abandon;
  logic                give_up;
  logic                bo_load;
  logic                bo_expired;
  logic [BO_LIMIT-1:0] rnd;

  txr_lfsr #(.OUT_W(BO_LIMIT)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rand_o (rnd)
  );

  txr_backoff #(
    .CNT_W       (CNT_W),
    .SLOT_CYCLES (SLOT_CYCLES),
    .BO_LIMIT    (BO_LIMIT)
  ) u_backoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (bo_load),
    .attempt_i (att_q),
    .rand_i    (rnd),
    .expired_o (bo_expired)
  );

  // collision outcome while an attempt runs
  always_comb begin
    abandon = coll_late_i && !lretx_q;
    give_up = !abandon && (single_q || (att_q == MAX_T));
    bo_load = (state_q == ST_TX) && coll_i && !abandon && !give_up;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      att_q      <= '0;
      late_q     <= 1'b0;
      single_q   <= 1'b0;
      lretx_q    <= 1'b0;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
      flags_q    <= '0;
      stat_att_q <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (frame_valid_i) begin
          state_q  <= ST_TX;
          att_q    <= CNT_W'(1);
          late_q   <= 1'b0;
          single_q <= cfg_single_try_i;
          lretx_q  <= cfg_late_retx_i;
          start_q  <= 1'b1;
        end
        ST_TX: if (coll_i) begin
          if (abandon || give_up) begin
            state_q           <= ST_IDLE;
            done_q            <= 1'b1;
            flags_q.retry_err <= give_up;
            flags_q.late      <= late_q | coll_late_i;
            stat_att_q        <= att_q;
          end else begin
            state_q <= ST_BACKOFF;
            late_q  <= late_q | coll_late_i;
          end
        end else if (tx_end_i) begin
          state_q           <= ST_IDLE;
          done_q            <= 1'b1;
          flags_q.retry_err <= 1'b0;
          flags_q.late      <= late_q;
          stat_att_q        <= att_q;
        end
        ST_BACKOFF: if (bo_expired) begin
          state_q <= ST_TX;
          att_q   <= att_q + 1'b1;
          start_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign frame_ready_o    = (state_q == ST_IDLE);
  assign attempt_start_o  = start_q;
  assign done_o           = done_q;
  assign stat_retry_err_o = flags_q.retry_err;
  assign stat_late_o      = flags_q.late;
  assign stat_attempts_o  = stat_att_q;

  // R2: an attempt is never commanded while the request side is open
  assert_ready_start_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_ready_o && attempt_start_o));
  // R9: done is a single-cycle strobe
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9: status is stable outside done cycles
  assert_status_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> ($stable(stat_attempts_o) || done_o));
  // R5: attempt count is capped
  assert_attempt_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= MAX_T);
  // R6: single-attempt mode never reaches a second attempt
  assert_single_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && single_q) |-> (att_q == CNT_W'(1)));
  // R7: late collision without retransmit abandons with late flag, no retry error
  assert_late_abandon_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && coll_i && coll_late_i && !lretx_q)
      |=> (done_o && stat_late_o && !stat_retry_err_o));
endmodule

// File: tb/txretry_ctrl_tb_top.sv
module txretry_ctrl_tb_top;
  localparam int MAXA = 16;
  localparam int SLOT = 1;
  localparam int BOL  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_single = 1'b0, cfg_lretx = 1'b0;
  logic valid = 1'b0, coll = 1'b0, coll_late = 1'b0, tx_end = 1'b0;
  logic ready, start, done, err, late;
  logic [4:0] atts;

  int n_chk = 0, n_fail = 0, cyc = 0;
  // reference model state: 0 idle, 1 attempt running, 2 backoff
  int m_st = 0, m_att = 0, w = 0, bound = 0;
  bit m_late = 0, m_single = 0, m_lretx = 0;
  bit m_err_o = 0, m_late_o = 0;
  int m_att_o = 0;

  always #4 clk = ~clk;

  txretry_ctrl #(.MAX_ATTEMPTS(MAXA), .SLOT_CYCLES(SLOT), .BO_LIMIT(BOL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_single_try_i(cfg_single), .cfg_late_retx_i(cfg_lretx),
    .frame_valid_i(valid), .frame_ready_o(ready), .coll_i(coll), .coll_late_i(coll_late),
    .tx_end_i(tx_end), .attempt_start_o(start), .done_o(done), .stat_retry_err_o(err),
    .stat_late_o(late), .stat_attempts_o(atts));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int win(input int n);
    int k = (n > BOL) ? BOL : n;
    return ((1 << k) - 1) * SLOT + 1;
  endfunction

  // one clock: model update from the inputs of this edge, compare at negedge
  task automatic step();
    bit e_start = 0, e_done = 0;
    @(posedge clk);
    case (m_st)
      0: if (valid) begin
        m_st = 1; m_att = 1; m_late = 0; m_single = cfg_single; m_lretx = cfg_lretx; e_start = 1;
      end
      1: if (coll) begin
        if (coll_late) m_late = 1;
        if (coll_late && !m_lretx) begin
          m_st = 0; e_done = 1; m_err_o = 0; m_late_o = m_late; m_att_o = m_att;
        end else if (m_single || m_att == MAXA) begin
          m_st = 0; e_done = 1; m_err_o = 1; m_late_o = m_late; m_att_o = m_att;
        end else begin
          m_st = 2; w = 0; bound = win(m_att);
        end
      end else if (tx_end) begin
        m_st = 0; e_done = 1; m_err_o = 0; m_late_o = m_late; m_att_o = m_att;
      end
      default: w++;
    endcase
    @(negedge clk);
    if (m_st == 2 && start) begin
      chk(w >= 1 && w <= bound, "R4 backoff wait", w, bound);
      m_st = 1; m_att++; e_start = 1;
    end else if (m_st == 2 && w >= bound) begin
      chk(0, "R4 restart missing", w, bound);
      m_st = 1; m_att++;
    end
    chk(ready == (m_st == 0), "R2 ready", ready, m_st == 0);
    chk(start == e_start, "R4 attempt_start", start, e_start);
    chk(done == e_done, "R9 done strobe", done, e_done);
    chk(err == m_err_o && late == m_late_o, "R3 status flags", {err, late}, {m_err_o, m_late_o});
    chk(int'(atts) == m_att_o, "R3 status attempts", atts, m_att_o);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic accept(input bit sgl, input bit lrx);
    cfg_single = sgl; cfg_lretx = lrx; valid = 1'b1;
    step();
    valid = 1'b0;
  endtask

  task automatic to_tx();
    for (int i = 0; i < 20000 && m_st != 1; i++) step();
  endtask

  task automatic collide(input bit lt);
    coll = 1'b1; coll_late = lt;
    step();
    coll = 1'b0; coll_late = 1'b0;
  endtask

  task automatic end_ok();
    tx_end = 1'b1;
    step();
    tx_end = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(ready && !start && !done && !err && !late && atts == 0, "R1 reset outputs",
        {ready, start, done, err, late}, 5'b10000);
    rst_n = 1'b1;
    quiet(2);

    // R2 and R3: hold valid through the frame; success on first attempt
    cfg_single = 0; cfg_lretx = 0; valid = 1'b1;
    step();
    quiet(3);
    chk(!ready && !done, "R2 valid ignored while busy", ready, 0);
    valid = 1'b0;
    end_ok();
    chk(done && !err && atts == 1, "R3 success after one attempt", atts, 1);
    quiet(2);

    // R4, R12: two collisions, stray inputs during backoff, then success
    accept(0, 0);
    collide(0);
    tx_end = 1'b1; coll = 1'b1;
    step();
    tx_end = 1'b0; coll = 1'b0;
    chk(!done, "R12 inputs during backoff ignored", done, 0);
    to_tx();
    collide(0);
    to_tx();
    end_ok();
    chk(done && !err && atts == 3, "R4 retry then success", atts, 3);
    quiet(2);

    // R10: collision and end on the same edge
    accept(0, 0);
    coll = 1'b1; tx_end = 1'b1;
    step();
    coll = 1'b0; tx_end = 1'b0;
    chk(!done && !ready, "R10 collision wins over end", done, 0);
    to_tx();
    end_ok();
    chk(atts == 2, "R10 second attempt counted", atts, 2);
    quiet(2);

    // R12: medium inputs while idle do nothing
    coll = 1'b1; tx_end = 1'b1; coll_late = 1'b1;
    quiet(2);
    coll = 1'b0; tx_end = 1'b0; coll_late = 1'b0;
    chk(ready && !done && atts == 2, "R12 idle inputs ignored", atts, 2);

    // R5: exhaustion
    accept(0, 0);
    for (int i = 0; i < MAXA - 1; i++) begin
      collide(0);
      to_tx();
    end
    collide(0);
    chk(done && err && atts == MAXA, "R5 retry exhaustion", atts, MAXA);
    quiet(3);
    chk(!start, "R5 no attempt after exhaustion", start, 0);

    // R6: single-attempt mode
    accept(1, 0);
    collide(0);
    chk(done && err && atts == 1, "R6 single attempt error", atts, 1);
    quiet(4);
    chk(!start && ready, "R6 no second attempt", start, 0);

    // R11: policy change mid-frame has no effect
    accept(0, 0);
    cfg_single = 1'b1;
    collide(0);
    chk(!done && !ready, "R11 captured policy kept", done, 0);
    to_tx();
    cfg_single = 1'b0;
    end_ok();
    chk(done && !err && atts == 2, "R11 frame completes", atts, 2);
    quiet(2);

    // R7: late collision abandoned
    accept(0, 0);
    collide(1);
    chk(done && !err && late && atts == 1, "R7 late abandon", {err, late}, 1);
    quiet(2);

    // R8: late collision retried, flag kept after success
    accept(0, 1);
    collide(1);
    chk(!done, "R8 late collision retried", done, 0);
    to_tx();
    end_ok();
    chk(done && !err && late && atts == 2, "R8 late flag kept", {err, late}, 1);
    quiet(2);

    // R6 and R8: single attempt with late retransmit gives retry error plus late flag
    accept(1, 1);
    collide(1);
    chk(done && err && late, "R6 single with late", {err, late}, 3);
    quiet(2);

    // R9: status held across idle cycles
    quiet(5);
    chk(err && late && atts == 1 && !done, "R9 status held", atts, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule